// File: doc/BRIEF.md
# Misaligned Access Detector

This block examines every memory request issued by a processor pipeline or an emulation core and decides whether the request breaks the alignment rule that is currently in force. It has four alignment policies, selected at run time by a 2-bit policy input. Each policy treats instruction fetches and data accesses separately. A mask input suppresses data-alignment faults, so that the access goes ahead as a legal unaligned access. Instruction-alignment faults are not affected by the mask.

Each valid request produces a registered result one cycle later. The result has three parts: a fault pulse, a 2-bit fault class and the effective address. In the policy that forces instruction targets onto 4-byte boundaries, the effective address has its two low bits cleared. The address of the first faulting request is captured and held until a clear pulse releases it.

Splitting unaligned accesses, exception dispatch and the bus itself belong to neighbouring logic.

Top module: `align_fault_unit`

## Requirements
- R1: After reset, `fault_o` is 0, `fault_cls_o` is 00, and both `eff_addr_o` and `trap_addr_o` are 0.
- R2: A byte access (size code 0) never faults, whatever the policy, kind or address.
- R3: Under policy 0 (strict), a word (size 1) or long (size 2 or 3) access with address bit 0 set faults. The class is 01 when the kind is fetch (kind 0) and 10 when the kind is data (kind 1, 2 or 3).
- R4: Under policy 1 (relaxed), data accesses never fault. A word or long fetch with address bit 0 set faults with class 01.
- R5: Under policy 2 (word-long), a word or long access faults when address bit 0 is set. A long access also faults when address bit 1 is set. The class is 01 for a fetch and 10 for data.
- R6: Under policy 3 (word-instruction), a fetch never faults. Its effective address is the request address with bits 1:0 cleared.
- R7: Under policy 3, integer data (kind 1) is never checked. Special data (kind 2 or 3) faults with class 10 when a word access has bit 0 set, or when a long access has bit 1 or bit 0 set.
- R8: While `dmask_i` is 1, no request produces class 10 and such a request gives no fault pulse. Instruction faults (class 01) are unaffected by `dmask_i`.
- R9: The fault pulse and class appear exactly one cycle after a request with `req_vld_i` high. A cycle with no valid request yields `fault_o` = 0 and class 00 one cycle later. Class 11 is never produced.
- R10: The raw address of the first faulting request is captured into `trap_addr_o` and held, and later faults do not overwrite it. A `clr_i` pulse empties it to 0. When `clr_i` and a fault arrive in the same cycle, the clear wins.
- R11: `eff_addr_o` is updated one cycle after each valid request and holds otherwise. It equals the request address in every case except a policy-3 fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | Request strobe |
| req_addr_i | input | AW | Request address |
| req_size_i | input | 2 | Size code: 0 byte, 1 word, 2 or 3 long |
| req_kind_i | input | 2 | Kind code: 0 fetch, 1 integer data, 2 or 3 special data |
| policy_i | input | 2 | 0 strict, 1 relaxed, 2 word-long, 3 word-instruction |
| dmask_i | input | 1 | Suppress data-alignment faults |
| clr_i | input | 1 | Release the captured fault address |
| fault_o | output | 1 | Fault pulse for the previous request |
| fault_cls_o | output | 2 | 00 none, 01 instruction, 10 data |
| eff_addr_o | output | AW | Effective address of the last valid request |
| trap_addr_o | output | AW | Held address of the first fault |

## Verification
The assertions assume that the policy, mask, size and kind inputs are known, meaning not X, whenever they are evaluated. The stimulus always drives them to defined codes, including while the strobe is low. The hold and clear properties assume that `clr_i` is a plain level sampled at the clock. The stimulus changes every input on the falling edge, so each value is stable at the rising edge that registers it. The stimulus also covers idle cycles that carry a misaligned address, and a clear that coincides with a fault.

// File: rtl/align_pkg.sv
package align_pkg;

    typedef enum logic [1:0] {
        POL_STRICT   = 2'd0,
        POL_RELAXED  = 2'd1,
        POL_WORDLONG = 2'd2,
        POL_WORDINSN = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        KD_FETCH   = 2'd0,
        KD_INT     = 2'd1,
        KD_SPECIAL = 2'd2,
        KD_OTHER   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_INSN = 2'd1,
        FC_DATA = 2'd2,
        FC_RSVD = 2'd3
    } fclass_e;

endpackage

// File: rtl/align_rule_eval.sv
module align_rule_eval
    import align_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [1:0]    policy_i,
    input  logic [1:0]    size_i,
    input  logic [1:0]    kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic          dmask_i,
    output logic [1:0]    cls_o,
    output logic [AW-1:0] eff_o
);
    localparam int LOW_BITS = 2;

    logic wide, is_long, is_fetch, is_special;
    logic odd_hit, pair_hit;
    logic insn_viol, data_viol;

    always_comb begin
        wide       = (size_i != SZ_BYTE);
        is_long    = size_i[1];
        is_fetch   = (kind_i == KD_FETCH);
        is_special = kind_i[1];
        odd_hit    = wide & addr_i[0];
        pair_hit   = odd_hit | (is_long & addr_i[1]);
        insn_viol  = 1'b0;
        data_viol  = 1'b0;
        unique case (policy_e'(policy_i))
            POL_STRICT: begin
                insn_viol = is_fetch & odd_hit;
                data_viol = ~is_fetch & odd_hit;
            end
            POL_RELAXED: begin
                insn_viol = is_fetch & odd_hit;
            end
            POL_WORDLONG: begin
                insn_viol = is_fetch & pair_hit;
                data_viol = ~is_fetch & pair_hit;
            end
            POL_WORDINSN: begin
                data_viol = is_special & pair_hit;
            end
            default: ;
        endcase

        if (insn_viol)
            cls_o = FC_INSN;
        else if (data_viol && !dmask_i)
            cls_o = FC_DATA;
        else
            cls_o = FC_NONE;

        eff_o = addr_i;
        if (policy_i == POL_WORDINSN && is_fetch)
            eff_o[LOW_BITS-1:0] = '0;
    end

    always_comb begin
        if (size_i == SZ_BYTE)
            assert_byte_never_faults_R2: assert (cls_o == FC_NONE);
        if (policy_i == POL_WORDINSN && kind_i == KD_FETCH)
            assert_wordinsn_fetch_clean_R6: assert (cls_o == FC_NONE && eff_o[1:0] == 2'b00);
        if (dmask_i)
            assert_mask_blocks_data_R8: assert (cls_o != FC_DATA);
        if (policy_i == POL_RELAXED && kind_i != KD_FETCH)
            assert_relaxed_data_free_R4: assert (cls_o == FC_NONE);
    end

endmodule

// File: rtl/align_fault_regs.sv
module align_fault_regs
    import align_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [1:0]    cls_i,
    input  logic [AW-1:0] eff_i,
    input  logic [AW-1:0] raw_i,
    input  logic          clr_i,
    output logic          fault_o,
    output logic [1:0]    cls_o,
    output logic [AW-1:0] eff_o,
    output logic [AW-1:0] trap_o
);
    typedef struct packed {
        logic          fault;
        logic [1:0]    cls;
        logic [AW-1:0] eff;
        logic          held;
        logic [AW-1:0] trap;
    } state_t;

    state_t st_d, st_q;
    logic   hit;

    always_comb begin
        st_d  = st_q;
        hit   = vld_i && (cls_i != FC_NONE);
        st_d.fault = hit;
        st_d.cls   = vld_i ? cls_i : FC_NONE;
        if (vld_i)
            st_d.eff = eff_i;
        if (clr_i) begin
            st_d.held = 1'b0;
            st_d.trap = '0;
        end else if (hit && !st_q.held) begin
            st_d.held = 1'b1;
            st_d.trap = raw_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign fault_o = st_q.fault;
    assign cls_o   = st_q.cls;
    assign eff_o   = st_q.eff;
    assign trap_o  = st_q.trap;

    assert_pulse_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && cls_i != FC_NONE) |=> (fault_o && cls_o != FC_NONE));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> (!fault_o && cls_o == FC_NONE));
    assert_class_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cls_o != FC_RSVD);
    assert_trap_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && !clr_i) |=> $stable(trap_o));
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (trap_o == '0));

endmodule

// File: rtl/align_fault_unit.sv
module align_fault_unit
    import align_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_vld_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [1:0]    req_size_i,
    input  logic [1:0]    req_kind_i,
    input  logic [1:0]    policy_i,
    input  logic          dmask_i,
    input  logic          clr_i,
    output logic          fault_o,
    output logic [1:0]    fault_cls_o,
    output logic [AW-1:0] eff_addr_o,
    output logic [AW-1:0] trap_addr_o
);
    logic [1:0]    cls_w;
    logic [AW-1:0] eff_w;

    align_rule_eval #(.AW(AW)) u_rules (
        .policy_i (policy_i),
        .size_i   (req_size_i),
        .kind_i   (req_kind_i),
        .addr_i   (req_addr_i),
        .dmask_i  (dmask_i),
        .cls_o    (cls_w),
        .eff_o    (eff_w)
    );

    align_fault_regs #(.AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (req_vld_i),
        .cls_i   (cls_w),
        .eff_i   (eff_w),
        .raw_i   (req_addr_i),
        .clr_i   (clr_i),
        .fault_o (fault_o),
        .cls_o   (fault_cls_o),
        .eff_o   (eff_addr_o),
        .trap_o  (trap_addr_o)
    );

endmodule

// File: tb/test_align_fault_unit.sv
module test_align_fault_unit;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_vld_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [1:0]    req_size_i = '0;
    logic [1:0]    req_kind_i = '0;
    logic [1:0]    policy_i = '0;
    logic          dmask_i = 1'b0;
    logic          clr_i = 1'b0;
    logic          fault_o;
    logic [1:0]    fault_cls_o;
    logic [AW-1:0] eff_addr_o;
    logic [AW-1:0] trap_addr_o;

    align_fault_unit #(.AW(AW)) i_align_fault_unit (.*);

    always #10 clk = ~clk;

    typedef struct {
        logic          fault;
        logic [1:0]    cls;
        logic [AW-1:0] eff;
        logic [AW-1:0] trap;
        string         tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic          m_held = 0;
    logic [AW-1:0] m_trap = '0;
    logic [AW-1:0] m_eff = '0;

    function automatic logic [1:0] model_cls(input logic [1:0] pol, input logic [1:0] sz,
            input logic [1:0] kd, input logic [AW-1:0] a, input logic msk);
        logic fetch = (kd == 2'd0);
        logic misal;
        logic [1:0] c = 2'b00;
        if (sz == 2'd0) return 2'b00;
        misal = (sz >= 2'd2) ? (a[1:0] != 2'b00) : a[0];
        case (pol)
            2'd0: if (a[0]) c = fetch ? 2'b01 : 2'b10;
            2'd1: if (a[0] && fetch) c = 2'b01;
            2'd2: if (misal) c = fetch ? 2'b01 : 2'b10;
            default: if (misal && kd >= 2'd2) c = 2'b10;
        endcase
        if (c == 2'b10 && msk) c = 2'b00;
        return c;
    endfunction

    task automatic req(input logic v, input logic [1:0] pol, input logic [1:0] sz,
            input logic [1:0] kd, input logic [AW-1:0] a, input logic msk,
            input logic clr, input string tag);
        exp_t e;
        logic [1:0] c;
        @(negedge clk);
        req_vld_i = v; policy_i = pol; req_size_i = sz; req_kind_i = kd;
        req_addr_i = a; dmask_i = msk; clr_i = clr;
        c = v ? model_cls(pol, sz, kd, a, msk) : 2'b00;
        if (v) m_eff = (pol == 2'd3 && kd == 2'd0) ? {a[AW-1:2], 2'b00} : a;
        if (clr) begin
            m_held = 0; m_trap = '0;
        end else if (c != 2'b00 && !m_held) begin
            m_held = 1; m_trap = a;
        end
        e.fault = (c != 2'b00); e.cls = c; e.eff = m_eff; e.trap = m_trap; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                @(negedge clk);
                checks++;
                if (fault_o !== e.fault || fault_cls_o !== e.cls ||
                    eff_addr_o !== e.eff || trap_addr_o !== e.trap) begin
                    errors++;
                    $display("FAIL %s: got fault=%0b cls=%0d eff=%h trap=%h exp fault=%0b cls=%0d eff=%h trap=%h",
                        e.tag, fault_o, fault_cls_o, eff_addr_o, trap_addr_o,
                        e.fault, e.cls, e.eff, e.trap);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (fault_o !== 1'b0 || fault_cls_o !== 2'b00 || eff_addr_o !== '0 || trap_addr_o !== '0) begin
            errors++;
            $display("FAIL R1: got fault=%0b cls=%0d eff=%h trap=%h exp all zero",
                fault_o, fault_cls_o, eff_addr_o, trap_addr_o);
        end
        rst_n = 1'b1;
        // strict policy
        req(1, 2'd0, 2'd1, 2'd1, 32'h0000_1001, 0, 0, "R3 strict word data odd");
        req(1, 2'd0, 2'd2, 2'd0, 32'h0000_2003, 0, 0, "R3 strict long fetch odd / R10 held");
        req(1, 2'd0, 2'd0, 2'd1, 32'h0000_3001, 0, 0, "R2 strict byte odd");
        req(1, 2'd0, 2'd2, 2'd1, 32'h0000_3002, 0, 0, "R3 strict long bit1 only");
        // relaxed
        req(1, 2'd1, 2'd2, 2'd1, 32'h0000_4003, 0, 0, "R4 relaxed data odd");
        req(1, 2'd1, 2'd1, 2'd0, 32'h0000_4005, 0, 0, "R4 relaxed fetch odd");
        req(1, 2'd1, 2'd0, 2'd0, 32'h0000_4007, 0, 0, "R2 relaxed byte fetch");
        // word-long
        req(1, 2'd2, 2'd2, 2'd1, 32'h0000_5002, 0, 0, "R5 long bit1");
        req(1, 2'd2, 2'd1, 2'd1, 32'h0000_5002, 0, 0, "R5 word bit1 ok");
        req(1, 2'd2, 2'd1, 2'd0, 32'h0000_5001, 0, 0, "R5 word fetch odd");
        req(1, 2'd2, 2'd3, 2'd2, 32'h0000_5004, 0, 0, "R5 long aligned");
        // word-instruction
        req(1, 2'd3, 2'd2, 2'd0, 32'h0000_6003, 0, 0, "R6 fetch forced aligned");
        req(1, 2'd3, 2'd2, 2'd1, 32'h0000_6003, 0, 0, "R7 int data unchecked / R11");
        req(1, 2'd3, 2'd2, 2'd2, 32'h0000_6002, 0, 0, "R7 special long bit1");
        req(1, 2'd3, 2'd1, 2'd3, 32'h0000_6001, 0, 0, "R7 special word odd");
        req(1, 2'd3, 2'd1, 2'd2, 32'h0000_6002, 0, 0, "R7 special word bit1 ok");
        // mask
        req(1, 2'd0, 2'd1, 2'd1, 32'h0000_7001, 1, 0, "R8 mask strict data");
        req(1, 2'd3, 2'd2, 2'd2, 32'h0000_7002, 1, 0, "R8 mask special");
        req(1, 2'd0, 2'd1, 2'd0, 32'h0000_7003, 1, 0, "R8 mask keeps insn");
        // idle with misaligned request fields
        req(0, 2'd0, 2'd2, 2'd1, 32'h0000_8001, 0, 0, "R9 no strobe");
        req(0, 2'd3, 2'd2, 2'd0, 32'h0000_8003, 0, 0, "R11 eff holds idle");
        // clear and recapture
        req(0, 2'd0, 2'd0, 2'd1, 32'h0000_0000, 0, 1, "R10 clear");
        req(1, 2'd2, 2'd2, 2'd1, 32'h0000_9006, 0, 0, "R10 recapture");
        req(1, 2'd2, 2'd1, 2'd1, 32'h0000_9101, 0, 0, "R10 no overwrite");
        req(1, 2'd0, 2'd1, 2'd1, 32'h0000_A001, 0, 1, "R10 clear wins");
        req(1, 2'd0, 2'd1, 2'd2, 32'h0000_B001, 0, 0, "R10 capture after clear");
        // sweep of all codes over low address bits
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 4; k++)
                    for (int a = 0; a < 4; a++)
                        req(1, 2'(p), 2'(s), 2'(k), 32'h0001_0000 + 32'(a) + 32'(p*64 + s*16 + k*4),
                            1'(a == 3 && k == 1), 1'(s == 3 && a == 0), "R2-sweep R3 R5 R7 R8");
        req(0, 2'd0, 2'd0, 2'd0, 32'h0, 0, 0, "R9 drain");
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule